// File: doc/BRIEF.md
# General-Purpose I/O Port with Break-Before-Make

This block controls a bank of bidirectional pins. For each pin it holds a level register and a direction register. From these it produces three pad controls: an output enable, an output value and a pull-up enable. Software reaches the block through a write strobe, a two-bit register select and a data bus, and reads it back through a combinational read bus.

A write of ones to the pin address flips the matching level bits, whatever direction each pin has. When a port-wide break-before-make enable is set, a pin that changes from input to output stays tri-stated for one clock before it drives its level. A pin that changes from output to input releases the pad at once. The gap is tracked per pin, so pins that are already outputs keep driving.

The register select uses 0 for level, 1 for direction, 2 for pin and 3 for control. In the control register, bit 0 is the break-before-make enable.

Top module: `gpio_bbm_port`

## Requirements
- R1: `pad_pu[i]` is 1 exactly when pin i is an input (direction bit 0) and its level bit is 1; otherwise it is 0.
- R2: When `pad_oe[i]` is 1, `pad_out[i]` equals the level bit of pin i. When `pad_oe[i]` is 0, `pad_out[i]` is 0.
- R3: A write with select 2 inverts every level bit whose `wdata` bit is 1 and leaves the others unchanged, for inputs and outputs alike.
- R4: While `rst_n` is low, `pad_oe` and `pad_pu` are all zero with no clock edge needed, and the level, direction and control registers are cleared.
- R5: With control bit 0 set, a pin whose direction bit goes from 0 to 1 keeps `pad_oe` low for the one cycle after the direction register updates, and drives from the following cycle.
- R6: A pin whose direction bit goes from 1 to 0 drops `pad_oe` in the cycle the direction register updates, with break-before-make on or off.
- R7: With control bit 0 clear, a pin switched to output drives in the same cycle the direction register updates.
- R8: With break-before-make on, a pin that is already driving and stays an output across a direction write keeps `pad_oe` high.
- R9: `rdata` returns the level register for select 0, the direction register for select 1, `pad_in` for select 2, and control bit 0 zero-extended for select 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 level, 1 direction, 2 pin, 3 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| pad_in | input | 8 | Pad input levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |
| pad_pu | output | 8 | Per-pin pull-up enable |

## Verification
The assertions assume that a control write and a direction write never fall in the same cycle, because the break-before-make enable is sampled at the edge that updates the direction register. The assertions also assume that `wr_en`, `reg_sel` and `wdata` are stable around the rising edge. The bench drives each write half a period away from the edge and issues one register access per cycle. Its back-to-back direction writes, which cancel or restart a gap, therefore never overlap a change of the enable.

// File: rtl/gpio_bbm_pkg.sv
package gpio_bbm_pkg;
  typedef enum logic [1:0] {
    SEL_LEVEL = 2'd0,
    SEL_DIR   = 2'd1,
    SEL_PIN   = 2'd2,
    SEL_CTRL  = 2'd3
  } port_sel_e;

  localparam int CTRL_BBM_BIT = 0;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_bbm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  port_sel_e    sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] level_q,
  output logic [W-1:0] dir_q,
  output logic         bbm_q,
  output logic [W-1:0] dir_rise,
  output logic [W-1:0] toggle_hit
);
  function automatic logic [W-1:0] flip_bits(input logic [W-1:0] cur, input logic [W-1:0] mask);
    return cur ^ mask;
  endfunction

  function automatic logic [W-1:0] rising_bits(input logic [W-1:0] old_v, input logic [W-1:0] new_v);
    return new_v & ~old_v;
  endfunction

  logic wr_level, wr_dir, wr_pin, wr_ctrl;
  logic [W-1:0] dir_next, level_next;

  assign wr_level   = wr_en && (sel == SEL_LEVEL);
  assign wr_dir     = wr_en && (sel == SEL_DIR);
  assign wr_pin     = wr_en && (sel == SEL_PIN);
  assign wr_ctrl    = wr_en && (sel == SEL_CTRL);

  assign dir_next   = wr_dir ? wdata : dir_q;
  assign dir_rise   = rising_bits(dir_q, dir_next);
  assign toggle_hit = wr_pin ? wdata : '0;
  assign level_next = wr_level ? wdata : flip_bits(level_q, toggle_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      dir_q   <= '0;
      bbm_q   <= 1'b0;
    end else begin
      level_q <= level_next;
      dir_q   <= dir_next;
      if (wr_ctrl) bbm_q <= wdata[CTRL_BBM_BIT];
    end
  end
endmodule

// File: rtl/gpio_bbm_gap.sv
module gpio_bbm_gap #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bbm_en,
  input  logic [W-1:0] dir_rise,
  output logic [W-1:0] gap_q
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gap_q[i] <= 1'b0;
      else        gap_q[i] <= bbm_en & dir_rise[i];
    end
  end
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
  parameter int W = 8
) (
  input  logic [W-1:0] level_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] gap_q,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_pu
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    assign pad_oe[i]  = dir_q[i] & ~gap_q[i];
    assign pad_out[i] = level_q[i] & pad_oe[i];
    assign pad_pu[i]  = level_q[i] & ~dir_q[i];
  end
endmodule

// File: rtl/gpio_bbm_port.sv
module gpio_bbm_port
  import gpio_bbm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   reg_sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_pu
);
  port_sel_e    sel;
  logic [W-1:0] level_q, dir_q, dir_rise, toggle_hit, gap_q;
  logic         bbm_q;

  assign sel = port_sel_e'(reg_sel);

  gpio_port_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .wdata(wdata),
    .level_q(level_q), .dir_q(dir_q), .bbm_q(bbm_q),
    .dir_rise(dir_rise), .toggle_hit(toggle_hit)
  );

  gpio_bbm_gap #(.W(W)) u_gap (
    .clk(clk), .rst_n(rst_n), .bbm_en(bbm_q), .dir_rise(dir_rise), .gap_q(gap_q)
  );

  gpio_pad_drive #(.W(W)) u_pad (
    .level_q(level_q), .dir_q(dir_q), .gap_q(gap_q),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  always_comb begin
    case (sel)
      SEL_LEVEL: rdata = level_q;
      SEL_DIR:   rdata = dir_q;
      SEL_PIN:   rdata = pad_in;
      default:   rdata = {{(W-1){1'b0}}, bbm_q};
    endcase
  end
endmodule

// File: rtl/gpio_bbm_port_chk.sv
module gpio_bbm_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [1:0]   reg_sel,
  input logic [W-1:0] wdata,
  input logic [W-1:0] level_q,
  input logic         bbm_q,
  input logic [W-1:0] dir_rise,
  input logic [W-1:0] toggle_hit,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] pad_pu
);
  // R1
  pu_drive_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0);

  // R3
  pin_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 2'd2) |=> level_q == ($past(level_q) ^ $past(wdata)));

  // R3
  toggle_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 2'd2) |-> toggle_hit == wdata);

  // R4
  reset_tristate_chk: assert property (@(posedge clk)
    !rst_n |-> (pad_oe == '0 && pad_pu == '0));

  // R5
  bbm_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bbm_q && dir_rise != '0) |=> (pad_oe & $past(dir_rise)) == '0);

  // R6
  out_to_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 2'd1) |=> (pad_oe & ~$past(wdata)) == '0);

  // R7
  direct_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bbm_q && wr_en && reg_sel == 2'd1) |=> pad_oe == $past(wdata));

  // R8
  keep_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 2'd1) |=> (pad_oe & $past(pad_oe & wdata)) == $past(pad_oe & wdata));
endmodule

bind gpio_bbm_port gpio_bbm_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel), .wdata(wdata),
  .level_q(level_q), .bbm_q(bbm_q), .dir_rise(dir_rise), .toggle_hit(toggle_hit),
  .pad_oe(pad_oe), .pad_pu(pad_pu)
);

// File: tb/tb_gpio_bbm_port.sv
module tb_gpio_bbm_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] pad_in = 8'h3C;
  logic [7:0] rdata, pad_oe, pad_out, pad_pu;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  string phase = "R4";

  // reference state
  logic [7:0] m_lvl = 8'h00, m_dir = 8'h00, m_gap = 8'h00;
  logic       m_bbm = 1'b0;

  gpio_bbm_port dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lvl = 8'h00; m_dir = 8'h00; m_gap = 8'h00; m_bbm = 1'b0;
    end else begin
      logic [7:0] new_gap;
      new_gap = 8'h00;
      if (wr_en) begin
        if (reg_sel == 2'd0) m_lvl = wdata;
        else if (reg_sel == 2'd1) begin
          for (int i = 0; i < 8; i++)
            new_gap[i] = m_bbm && wdata[i] && !m_dir[i];
          m_dir = wdata;
        end else if (reg_sel == 2'd2) begin
          for (int i = 0; i < 8; i++)
            if (wdata[i]) m_lvl[i] = !m_lvl[i];
        end else m_bbm = wdata[0];
      end
      m_gap = new_gap;
    end
  end

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s (phase %s) %s actual=%h expected=%h", req, phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [7:0] e_oe, e_out, e_pu, e_rd;
    for (int i = 0; i < 8; i++) begin
      e_oe[i]  = (m_dir[i] == 1'b1) && (m_gap[i] == 1'b0);
      e_out[i] = e_oe[i] ? m_lvl[i] : 1'b0;
      e_pu[i]  = (m_dir[i] == 1'b0) && (m_lvl[i] == 1'b1);
    end
    case (reg_sel)
      2'd0: e_rd = m_lvl;
      2'd1: e_rd = m_dir;
      2'd2: e_rd = pad_in;
      default: e_rd = {7'b0, m_bbm};
    endcase
    check("R5/R6/R7/R8", "pad_oe", pad_oe, e_oe);
    check("R2", "pad_out", pad_out, e_out);
    check("R1", "pad_pu", pad_pu, e_pu);
    check("R9", "rdata", rdata, e_rd);
  end

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; reg_sel = s; wdata = d;
  endtask

  task automatic idle(input int n);
    @(negedge clk); #1;
    wr_en = 1'b0;
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    // R4: reset state while held low
    #2;
    check("R4", "oe in reset", pad_oe, 8'h00);
    check("R4", "pu in reset", pad_pu, 8'h00);
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    idle(1);

    // R1: pull-ups on inputs with level one
    phase = "R1";
    wr(2'd0, 8'hA5); idle(2);
    // R7: direct drive without break-before-make
    phase = "R7";
    wr(2'd1, 8'h0F); idle(2);
    // R3: toggle across inputs and outputs
    phase = "R3";
    wr(2'd2, 8'hFF); idle(1);
    wr(2'd2, 8'h00); idle(1);
    wr(2'd2, 8'h81); idle(1);
    // R6: output to input without gap
    phase = "R6";
    wr(2'd1, 8'h00); idle(2);
    // R9: readback including control and pad inputs
    phase = "R9";
    wr(2'd3, 8'hFF); idle(0);
    reg_sel = 2'd3; @(negedge clk); #1;
    reg_sel = 2'd2; pad_in = 8'hC3; @(negedge clk); #1;
    // R5: one-cycle gap
    phase = "R5";
    wr(2'd1, 8'h0F); idle(3);
    // R8: existing outputs undisturbed
    phase = "R8";
    wr(2'd1, 8'hFF); idle(3);
    // R6 with break-before-make on, then cancel and restart gaps back-to-back
    phase = "R6";
    wr(2'd1, 8'hF0); wr(2'd1, 8'h0F); wr(2'd1, 8'h00); wr(2'd1, 8'h3C); idle(3);
    // R7 after disabling
    phase = "R7";
    wr(2'd3, 8'h00); wr(2'd1, 8'hC3); idle(2);

    // pseudo-random sweep
    phase = "R5";
    lf = 16'hACE1;
    for (int k = 0; k < 300; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      pad_in = lf[15:8];
      if (lf[3]) begin
        wr(lf[1:0], lf[11:4]);
      end else begin
        idle(0);
        reg_sel = lf[1:0];
      end
    end
    idle(2);

    // R4: asynchronous reset mid-run with outputs driving
    phase = "R4";
    wr(2'd1, 8'hFF); idle(1);
    reg_sel = 2'd1;
    #2 rst_n = 1'b0;
    #1;
    check("R4", "oe async", pad_oe, 8'h00);
    check("R4", "dir cleared", rdata, 8'h00);
    check("R4", "pu async", pad_pu, 8'h00);
    @(negedge clk); #1 rst_n = 1'b1;
    idle(2);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule